// File: doc/BRIEF.md
# PS/2 Host Command Sender

This block is the host end of a PS/2 link when the host has a command byte for the attached device. A one-cycle start strobe captures the byte. The block then holds the shared clock line low to stop the device talking. It pulls the data line low and lets the clock go, which asks the device to start clocking. From then on it follows the clock that the device generates. It puts each of the eight data bits on the line, least significant bit first, then the odd parity bit. Each new bit is placed just after a falling clock edge, so the device reads a settled level while the clock is high. After the parity bit it lets the data line go. It then waits for the device's acknowledge pulse and for both lines to return high.

Both lines are open-collector. The block never drives them high. It has a pull-low enable for each line and reads each line back. The read-back clock and data pass through a synchronizer before any edge or level is used. Two watchdogs guard the exchange, and both are counted in system-clock ticks. One covers the wait for the device to begin clocking. The other covers the packet itself. If either one expires, the block gives up, releases both lines and pulses its error output. A normal finish pulses its done output.

Top module: `ps2_cmd_tx`

## Requirements
- R1: After reset the block is idle: `busy`, `done` and `error` are low and neither pull enable is asserted.
- R2: A start strobe while idle captures the byte and holds `clkPullEn` high for exactly INHIBIT_TICKS+1 cycles. In the last of those cycles `datPullEn` is also high. When the clock pull ends, the data pull stays asserted, so the bus shows clock released and data low.
- R3: The data line is only changed while the clock line is low. Data bit n (n = 0 for the least significant bit) is on the line by the rising clock edge that follows the (n+1)-th falling edge seen after request-to-send. The value on the line is the bit itself: a 0 is driven low and a 1 is released.
- R4: The ninth bit, read at the ninth rising edge, is the odd parity bit. It makes the count of ones across the eight data bits and itself an odd number.
- R5: At the tenth falling edge the block releases data, so the tenth rising edge reads 1. It then waits for the device to pull data low, then for the clock to go low, then for both lines to be high. At that point it pulses `done` for one cycle and drops `busy`.
- R6: If no falling clock edge arrives within START_LIMIT cycles of the start strobe, `error` pulses within START_LIMIT to START_LIMIT+4 cycles of the strobe. Both pull enables are released in the same cycle as the error pulse.
- R7: If more than PACKET_LIMIT cycles pass between the first falling clock edge and completion, `error` pulses, both lines are released and no `done` follows. This covers a device that clocks too slowly and a device that never acknowledges.
- R8: A start strobe that arrives while `busy` is high has no effect. The byte being sent does not change, and no new exchange begins after the current one ends.
- R9: `done` and `error` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| txByte | input | 8 | Command byte, captured on an accepted start |
| txStart | input | 1 | Start strobe, one cycle |
| busy | output | 1 | High from acceptance until done or error |
| done | output | 1 | One-cycle pulse on successful completion |
| error | output | 1 | One-cycle pulse on a start or packet timeout |
| clkPullEn | output | 1 | 1 pulls the PS/2 clock line low |
| datPullEn | output | 1 | 1 pulls the PS/2 data line low |
| clkIn | input | 1 | Read-back level of the PS/2 clock line |
| datIn | input | 1 | Read-back level of the PS/2 data line |

## Verification
The assertions check, on every cycle, the properties that need no model of the device. Done and error never coincide. Both lines are released whenever an error or done pulse is present. Data is still pulled at the moment the clock pull ends. A strobe arriving while busy never reloads the shift register. A freshly loaded frame always has odd parity, and a shift is never requested past the last bit. The bench's device model is the only way to show the bit order and value on the wire, the stop level, the acknowledge sequence and how long the inhibit lasts. Its timeout scenarios show where in time the two watchdogs fire, with a silent device, with a slow device and with a device that never acknowledges.

// File: rtl/ps2_cmd_pkg.sv
package ps2_cmd_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_INHIBIT,
    S_ARM,
    S_RTS,
    S_SEND,
    S_STOP,
    S_ACKDAT,
    S_ACKCLK,
    S_RELEASE
  } txState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic shift;
    logic pktStart;
  } dpStrobe_t;

  // conditions reported by the datapath
  typedef struct packed {
    logic inhibitDone;
    logic startLate;
    logic pktLate;
    logic clkFall;
    logic clkHigh;
    logic datHigh;
    logic lastBit;
    logic curBit;
  } dpStatus_t;

endpackage

// File: rtl/ps2_cmd_dp.sv
module ps2_cmd_dp
  import ps2_cmd_pkg::*;
#(
  parameter int DATA_BITS     = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int INHIBIT_TICKS = 5000,
  parameter int START_LIMIT   = 750000,
  parameter int PACKET_LIMIT  = 100000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DATA_BITS-1:0] txByte,
  input  logic                 clkIn,
  input  logic                 datIn,
  input  dpStrobe_t            strobe,
  output dpStatus_t            status
);

  localparam int INH_W = $clog2(INHIBIT_TICKS + 1);
  localparam int ST_W  = $clog2(START_LIMIT + 1);
  localparam int PK_W  = $clog2(PACKET_LIMIT + 1);
  localparam int CNT_W = $clog2(DATA_BITS + 2);

  logic [SYNC_STAGES-1:0] clkSync;
  logic [SYNC_STAGES-1:0] datSync;
  logic                   clkPrev;
  logic [INH_W-1:0]       phaseCnt;
  logic [ST_W-1:0]        startCnt;
  logic [PK_W-1:0]        pktCnt;
  logic [DATA_BITS:0]     frame;
  logic [CNT_W-1:0]       bitCnt;

  // read-back synchronizers, released level at reset
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) begin
          clkSync[0] <= 1'b1;
          datSync[0] <= 1'b1;
        end else begin
          clkSync[0] <= clkIn;
          datSync[0] <= datIn;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) begin
          clkSync[g] <= 1'b1;
          datSync[g] <= 1'b1;
        end else begin
          clkSync[g] <= clkSync[g-1];
          datSync[g] <= datSync[g-1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) clkPrev <= 1'b1;
    else       clkPrev <= clkSync[SYNC_STAGES-1];
  end

  // inhibit phase counter
  always_ff @(posedge clk) begin
    if (!rstN)                   phaseCnt <= '0;
    else if (strobe.load)        phaseCnt <= '0;
    else if (!status.inhibitDone) phaseCnt <= phaseCnt + 1'b1;
  end

  // start watchdog, saturating
  always_ff @(posedge clk) begin
    if (!rstN)                               startCnt <= '0;
    else if (strobe.load)                    startCnt <= '0;
    else if (startCnt != ST_W'(START_LIMIT)) startCnt <= startCnt + 1'b1;
  end

  // packet watchdog, saturating
  always_ff @(posedge clk) begin
    if (!rstN)                              pktCnt <= '0;
    else if (strobe.pktStart)               pktCnt <= '0;
    else if (pktCnt != PK_W'(PACKET_LIMIT)) pktCnt <= pktCnt + 1'b1;
  end

  // frame shifter: data bits then odd parity, refilled with released level
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frame  <= '1;
      bitCnt <= '0;
    end else if (strobe.load) begin
      frame  <= {~^txByte, txByte};
      bitCnt <= '0;
    end else if (strobe.shift) begin
      frame  <= {1'b1, frame[DATA_BITS:1]};
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    status.inhibitDone = (phaseCnt == INH_W'(INHIBIT_TICKS - 1));
    status.startLate   = (startCnt == ST_W'(START_LIMIT));
    status.pktLate     = (pktCnt == PK_W'(PACKET_LIMIT));
    status.clkHigh     = clkSync[SYNC_STAGES-1];
    status.datHigh     = datSync[SYNC_STAGES-1];
    status.clkFall     = clkPrev & ~clkSync[SYNC_STAGES-1];
    status.lastBit     = (bitCnt == CNT_W'(DATA_BITS));
    status.curBit      = frame[0];
  end

  p_parity_odd_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.load) |-> (^frame == 1'b1));

  p_bitcnt_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(DATA_BITS));

  p_shift_in_frame_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |-> (bitCnt < CNT_W'(DATA_BITS)));

endmodule

// File: rtl/ps2_cmd_ctrl.sv
module ps2_cmd_ctrl
  import ps2_cmd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      txStart,
  input  dpStatus_t status,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      done,
  output logic      error,
  output logic      clkPullEn,
  output logic      datPullEn
);

  txState_t state, nxt;
  logic     finishOk, fail;

  always_comb begin
    nxt      = state;
    strobe   = '0;
    finishOk = 1'b0;
    fail     = 1'b0;
    unique case (state)
      S_IDLE: if (txStart) begin
        strobe.load = 1'b1;
        nxt         = S_INHIBIT;
      end
      S_INHIBIT: begin
        if (status.startLate)        fail = 1'b1;
        else if (status.inhibitDone) nxt  = S_ARM;
      end
      S_ARM: nxt = S_RTS;
      S_RTS: begin
        if (status.startLate) fail = 1'b1;
        else if (status.clkFall) begin
          strobe.pktStart = 1'b1;
          nxt             = S_SEND;
        end
      end
      S_SEND: begin
        if (status.pktLate) fail = 1'b1;
        else if (status.clkFall) begin
          if (status.lastBit) nxt          = S_STOP;
          else                strobe.shift = 1'b1;
        end
      end
      S_STOP: begin
        if (status.pktLate)      fail = 1'b1;
        else if (status.datHigh) nxt  = S_ACKDAT;
      end
      S_ACKDAT: begin
        if (status.pktLate)       fail = 1'b1;
        else if (!status.datHigh) nxt  = S_ACKCLK;
      end
      S_ACKCLK: begin
        if (status.pktLate)       fail = 1'b1;
        else if (!status.clkHigh) nxt  = S_RELEASE;
      end
      S_RELEASE: begin
        if (status.pktLate) fail = 1'b1;
        else if (status.clkHigh && status.datHigh) begin
          finishOk = 1'b1;
          nxt      = S_IDLE;
        end
      end
      default: nxt = S_IDLE;
    endcase
    if (fail) nxt = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      state <= nxt;
      done  <= finishOk;
      error <= fail;
    end
  end

  assign busy      = (state != S_IDLE);
  assign clkPullEn = (state == S_INHIBIT) || (state == S_ARM);
  assign datPullEn = (state == S_ARM) || (state == S_RTS) ||
                     ((state == S_SEND) && !status.curBit);

  p_done_error_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));

  p_release_on_error_r6: assert property (@(posedge clk) disable iff (!rstN)
    error |-> (!clkPullEn && !datPullEn && !busy));

  p_done_released_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!clkPullEn && !datPullEn && !busy));

  p_rts_order_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(clkPullEn) && busy) |-> datPullEn);

  p_ignore_busy_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && txStart) |-> !strobe.load);

endmodule

// File: rtl/ps2_cmd_tx.sv
module ps2_cmd_tx
  import ps2_cmd_pkg::*;
#(
  parameter int DATA_BITS     = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int INHIBIT_TICKS = 5000,
  parameter int START_LIMIT   = 750000,
  parameter int PACKET_LIMIT  = 100000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DATA_BITS-1:0] txByte,
  input  logic                 txStart,
  output logic                 busy,
  output logic                 done,
  output logic                 error,
  output logic                 clkPullEn,
  output logic                 datPullEn,
  input  logic                 clkIn,
  input  logic                 datIn
);

  dpStrobe_t strobe;
  dpStatus_t status;

  ps2_cmd_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .txStart   (txStart),
    .status    (status),
    .strobe    (strobe),
    .busy      (busy),
    .done      (done),
    .error     (error),
    .clkPullEn (clkPullEn),
    .datPullEn (datPullEn)
  );

  ps2_cmd_dp #(
    .DATA_BITS     (DATA_BITS),
    .SYNC_STAGES   (SYNC_STAGES),
    .INHIBIT_TICKS (INHIBIT_TICKS),
    .START_LIMIT   (START_LIMIT),
    .PACKET_LIMIT  (PACKET_LIMIT)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .txByte (txByte),
    .clkIn  (clkIn),
    .datIn  (datIn),
    .strobe (strobe),
    .status (status)
  );

endmodule

// File: tb/sim_ps2_cmd_tx.sv
module sim_ps2_cmd_tx;

  localparam int INH  = 8;
  localparam int STL  = 100;
  localparam int PKL  = 400;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] txByte = '0;
  logic       txStart = 1'b0;
  logic       busy, done, error, clkPullEn, datPullEn;
  logic       devClk = 1'b1;
  logic       devDat = 1'b1;
  logic       clkLine, datLine;
  logic       prevDatPull = 1'b0;
  int         checks = 0;
  int         fails = 0;
  int         doneCnt = 0;
  int         errCnt = 0;

  always #10 clk = ~clk;

  assign clkLine = ~clkPullEn & devClk;
  assign datLine = ~datPullEn & devDat;

  ps2_cmd_tx #(
    .DATA_BITS(8), .SYNC_STAGES(2), .INHIBIT_TICKS(INH),
    .START_LIMIT(STL), .PACKET_LIMIT(PKL)
  ) u0 (
    .clk(clk), .rstN(rstN), .txByte(txByte), .txStart(txStart),
    .busy(busy), .done(done), .error(error),
    .clkPullEn(clkPullEn), .datPullEn(datPullEn),
    .clkIn(clkLine), .datIn(datLine)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pulse counting, R9 exclusivity, R3 data changes only with clock low
  always @(negedge clk) begin
    if (rstN) begin
      if (done)  doneCnt++;
      if (error) errCnt++;
      if (done || error) check(!(done && error), "R9 done/error overlap", int'(done & error), 0);
      if (datPullEn != prevDatPull && !error)
        check(clkLine == 1'b0, "R3 data moved with clock high", int'(clkLine), 0);
    end
    prevDatPull <= datPullEn;
  end

  // device model: h = half clock period in system cycles; rx[k-1] read at rise k
  task automatic frame(input logic [7:0] b, input int h, input bit doAck,
                       input bit inject, output logic [9:0] rx, output int inh);
    @(negedge clk); txByte = b; txStart = 1'b1;
    @(negedge clk); txStart = 1'b0;
    inh = 0;
    while (clkPullEn && inh < 1000) begin
      inh++;
      @(negedge clk);
    end
    check(clkLine == 1'b1 && datLine == 1'b0, "R2 request-to-send bus state",
          int'({clkLine, datLine}), 2);
    for (int k = 1; k <= 10; k++) begin
      repeat (h) @(negedge clk);
      devClk = 1'b0;
      if (inject && k == 5) begin
        @(negedge clk); txByte = ~b; txStart = 1'b1;
        @(negedge clk); txStart = 1'b0;
        repeat (h - 2) @(negedge clk);
      end else begin
        repeat (h) @(negedge clk);
      end
      devClk = 1'b1;
      rx[k-1] = datLine;
    end
    repeat (h / 2) @(negedge clk);
    if (doAck) devDat = 1'b0;
    repeat (h / 2) @(negedge clk);
    devClk = 1'b0;
    repeat (h) @(negedge clk);
    devClk = 1'b1;
    repeat (h / 2) @(negedge clk);
    devDat = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    logic [9:0] rx;
    int inh, d0, e0, cnt;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !error, "R1 idle outputs", int'({busy, done, error}), 0);
    check(!clkPullEn && !datPullEn, "R1 lines released", int'({clkPullEn, datPullEn}), 0);

    // sweep of every byte value with varying device clock speed
    for (int v = 0; v < 256; v++) begin
      int h;
      h = 8 + 2 * (v % 3);
      d0 = doneCnt; e0 = errCnt;
      frame(8'(v), h, 1'b1, 1'b0, rx, inh);
      if (v < 4) check(inh == INH + 1, "R2 inhibit length", inh, INH + 1);
      check(rx[7:0] == 8'(v), "R3 data bits LSB first", int'(rx[7:0]), v);
      check(rx[8] == ~^8'(v), "R4 odd parity", int'(rx[8]), int'(~^8'(v)));
      check(rx[9] == 1'b1, "R5 stop level released", int'(rx[9]), 1);
      check(doneCnt == d0 + 1 && errCnt == e0, "R5 done pulse", doneCnt - d0, 1);
      check(!busy, "R5 idle after done", int'(busy), 0);
    end

    // R8 start while busy ignored
    d0 = doneCnt;
    frame(8'hA5, 10, 1'b1, 1'b1, rx, inh);
    check(rx[7:0] == 8'hA5, "R8 byte unchanged by busy start", int'(rx[7:0]), 'hA5);
    check(doneCnt == d0 + 1, "R8 one completion", doneCnt - d0, 1);
    repeat (30) @(negedge clk);
    check(!busy && !clkPullEn, "R8 no second exchange", int'({busy, clkPullEn}), 0);

    // R6 start timeout: device silent
    e0 = errCnt;
    @(negedge clk); txByte = 8'h3C; txStart = 1'b1;
    cnt = 0;
    @(negedge clk); txStart = 1'b0; cnt = 1;
    while (!error && cnt < 400) begin
      @(negedge clk);
      cnt++;
    end
    check(error == 1'b1 && cnt >= STL && cnt <= STL + 4, "R6 start timeout timing", cnt, STL + 2);
    check(!clkPullEn && !datPullEn, "R6 lines released on error", int'({clkPullEn, datPullEn}), 0);
    repeat (5) @(negedge clk);
    check(errCnt == e0 + 1 && !busy, "R6 single error, idle", errCnt - e0, 1);

    // R7 packet timeout: slow device
    d0 = doneCnt; e0 = errCnt;
    frame(8'h5A, 30, 1'b1, 1'b0, rx, inh);
    check(errCnt == e0 + 1 && doneCnt == d0, "R7 slow device error", errCnt - e0, 1);
    check(!clkPullEn && !datPullEn && !busy, "R7 released after error",
          int'({clkPullEn, datPullEn, busy}), 0);

    // R7 packet timeout: no acknowledge
    d0 = doneCnt; e0 = errCnt;
    frame(8'hC3, 10, 1'b0, 1'b0, rx, inh);
    repeat (PKL) @(negedge clk);
    check(errCnt == e0 + 1 && doneCnt == d0, "R7 missing ack error", errCnt - e0, 1);
    check(!clkPullEn && !datPullEn && !busy, "R7 released after ack error",
          int'({clkPullEn, datPullEn, busy}), 0);

    // recovery: normal exchange after errors
    d0 = doneCnt;
    frame(8'h81, 10, 1'b1, 1'b0, rx, inh);
    check(rx[7:0] == 8'h81 && doneCnt == d0 + 1, "R5 recovery after error", int'(rx[7:0]), 'h81);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule